// File: doc/BRIEF.md
# Single-Clock FIFO with Same-Cycle Pass-Through

This block is a single-clock first-in, first-out queue with a valid/ready write side and a valid/ready read side. Its read and write positions are kept as counters one bit wider than the storage address. The extra top bit lets the block tell a full queue from an empty one without a separate occupancy counter. A registered tracking flag holds both handshake sides idle while reset is asserted and for one more cycle after it is released. This gives the surrounding logic a clean first cycle before any transfer.

A build-time switch selects a pass-through variant. In that variant, a write offered to an empty queue is shown on the read side in the same cycle. If the reader takes it in that same cycle, the item never enters storage. Without the switch, a written item becomes visible on the cycle after it is stored. Typical use is as an elastic stage between a request source and a consumer that sits close to it, where the saved cycle of latency matters.

Top module: `fifo_pt`

## Requirements
- R1: While `rst` is sampled high and immediately after it, the block reports `empty_o`=1 and `full_o`=0, and `rvalid_o` is 0.
- R2: `rvalid_o` and `wready_o` stay 0 during reset and through the first clock cycle after the first rising edge that samples `rst` low. `wready_o` becomes 1 after the second such edge.
- R3: Items leave the read side in the order in which they were accepted (`wvalid_i`=1 and `wready_o`=1 at a rising edge), and each accepted item leaves once.
- R4: After DEPTH accepted writes with no reads, `full_o`=1 and `wready_o`=0. A write offered while full is not accepted and never appears on the read side. `full_o` stays 1 until a read is taken.
- R5: When nothing is stored and `wvalid_i`=0, `empty_o`=1 and `rvalid_o`=0. `empty_o` and `full_o` are never 1 together.
- R6: With PASS_THRU=1, a write offered to an empty queue (outside the reset window) drives `rvalid_o`=1, `empty_o`=0 and `rdata_o`=`wdata_i` in the same cycle.
- R7: With PASS_THRU=1, a write to an empty queue that is also read in the same cycle is not stored: the queue is still empty on the next cycle.
- R8: With PASS_THRU=1, a write to an empty queue that is not read in that cycle is stored, and it is presented from storage on the following cycle.
- R9: A read and a write taken in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged.
- R10: With PASS_THRU=0, a write to an empty queue leaves `rvalid_o`=0 and `empty_o`=1 in that cycle. The item is presented on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wvalid_i | input | 1 | Write side offers an item |
| wready_o | output | 1 | Queue accepts an item this cycle |
| wdata_i | input | WIDTH | Item offered on the write side |
| rvalid_o | output | 1 | Read side presents an item |
| rready_i | input | 1 | Reader takes the presented item |
| rdata_o | output | WIDTH | Item presented on the read side |
| full_o | output | 1 | All DEPTH entries occupied |
| empty_o | output | 1 | Nothing to present (with PASS_THRU=1, also requires no write offered) |

## Verification
A pointer that slips by one shows up at the ports in one of two ways. Either a read returns an item out of order or twice, on the very read where the slip occurs. Or `full_o` rises one write early or late, on the write that reaches DEPTH. A wrong wrap bit makes a full queue look empty, or an empty one look full. This is visible on the same cycle, because `rvalid_o` and `wready_o` take the wrong values. A stuck tracking flag shows as a `wready_o` that rises one cycle too early or too late after reset. A bypass that wrongly stores its item shows one cycle later, as a spurious `rvalid_o` with a duplicate item.

// File: rtl/fifo_pt_pkg.sv
package fifo_pt_pkg;

  function automatic int addr_bits(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction

  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/fifo_pt_ptr.sv
module fifo_pt_ptr #(
  parameter int AW = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inc_i,
  output logic [AW:0] ptr_o
);

  logic [AW:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ptr_o = cnt_q;

endmodule

// File: rtl/fifo_pt_mem.sv
module fifo_pt_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int AW = fifo_pt_pkg::addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      store_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = store_q[raddr_i];

endmodule

// File: rtl/fifo_pt_rst_track.sv
module fifo_pt_rst_track (
  input  logic clk,
  input  logic rst,
  output logic in_rst_o
);

  logic rst_seen_q;
  logic in_rst_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    in_rst_q   <= rst | rst_seen_q;
  end

  assign in_rst_o = in_rst_q;

endmodule

// File: rtl/fifo_pt.sv
module fifo_pt #(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 4,
  parameter bit PASS_THRU = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wvalid_i,
  output logic             wready_o,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);

  localparam int AW = fifo_pt_pkg::addr_bits(DEPTH);

  if (!fifo_pt_pkg::is_pow2(DEPTH)) begin : g_bad_depth
    $error("fifo_pt: DEPTH must be a power of two and at least 2");
  end

  logic [AW:0]      wptr;
  logic [AW:0]      rptr;
  logic             under_rst;
  logic             core_empty;
  logic             core_full;
  logic             wr_fire;
  logic             rd_fire;
  logic             bypass;
  logic             wr_adv;
  logic             rd_adv;
  logic [WIDTH-1:0] mem_rdata;

  fifo_pt_rst_track u_track (
    .clk      (clk),
    .rst      (rst),
    .in_rst_o (under_rst)
  );

  fifo_pt_ptr #(.AW(AW)) u_wptr (
    .clk   (clk),
    .rst   (rst),
    .inc_i (wr_adv),
    .ptr_o (wptr)
  );

  fifo_pt_ptr #(.AW(AW)) u_rptr (
    .clk   (clk),
    .rst   (rst),
    .inc_i (rd_adv),
    .ptr_o (rptr)
  );

  fifo_pt_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .we_i    (wr_adv),
    .waddr_i (wptr[AW-1:0]),
    .wdata_i (wdata_i),
    .raddr_i (rptr[AW-1:0]),
    .rdata_o (mem_rdata)
  );

  // Equal counters mean empty; equal address with differing wrap means full.
  assign core_empty = (wptr == rptr);
  assign core_full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

  assign wready_o = ~core_full & ~under_rst;
  assign wr_fire  = wvalid_i & wready_o;
  assign rvalid_o = ~empty_o & ~under_rst;
  assign rd_fire  = rvalid_o & rready_i;
  assign full_o   = core_full;

  if (PASS_THRU) begin : g_pass
    assign empty_o = core_empty & ~wvalid_i;
    assign rdata_o = core_empty ? wdata_i : mem_rdata;
    assign bypass  = core_empty & wr_fire & rd_fire;
  end else begin : g_plain
    assign empty_o = core_empty;
    assign rdata_o = mem_rdata;
    assign bypass  = 1'b0;
  end

  assign wr_adv = wr_fire & ~bypass;
  assign rd_adv = rd_fire & ~bypass;

endmodule

// File: rtl/fifo_pt_chk.sv
module fifo_pt_chk #(
  parameter int WIDTH     = 8,
  parameter bit PASS_THRU = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             wvalid_i,
  input logic             wready_o,
  input logic [WIDTH-1:0] wdata_i,
  input logic             rvalid_o,
  input logic             rready_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             core_empty
);

  AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || $past(rst, 2)) |-> (!rvalid_o && !wready_o)); // R2

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    full_o |-> !wready_o); // R4

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full_o && !(rvalid_o && rready_i)) |=> full_o); // R4

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    empty_o |-> !rvalid_o); // R5

  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !(full_o && empty_o)); // R5

  AST_PASS_ECHO: assert property (@(posedge clk) disable iff (rst)
    (PASS_THRU && core_empty && wvalid_i && wready_o)
      |-> (rvalid_o && rdata_o == wdata_i)); // R6

  AST_BYPASS_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    (PASS_THRU && core_empty && wvalid_i && wready_o && rready_i)
      |=> core_empty); // R7

  AST_PLAIN_NO_ECHO: assert property (@(posedge clk) disable iff (rst)
    (!PASS_THRU && core_empty) |-> !rvalid_o); // R10

endmodule

bind fifo_pt fifo_pt_chk #(.WIDTH(WIDTH), .PASS_THRU(PASS_THRU)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wvalid_i   (wvalid_i),
  .wready_o   (wready_o),
  .wdata_i    (wdata_i),
  .rvalid_o   (rvalid_o),
  .rready_i   (rready_i),
  .rdata_o    (rdata_o),
  .full_o     (full_o),
  .empty_o    (empty_o),
  .core_empty (core_empty)
);

// File: tb/fifo_pt_test.sv
module fifo_pt_test;
  localparam int W = 8;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wvalid = 1'b0, rready = 1'b0;
  logic [W-1:0] wdata = '0;
  logic wready, rvalid, full, empty;
  logic [W-1:0] rdata;
  logic np_wvalid = 1'b0, np_rready = 1'b0;
  logic [W-1:0] np_wdata = '0;
  logic np_wready, np_rvalid, np_full, np_empty;
  logic [W-1:0] np_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] expq[$];

  always #5 clk = ~clk;

  fifo_pt #(.WIDTH(W), .DEPTH(D), .PASS_THRU(1'b1)) uut (
    .clk(clk), .rst(rst), .wvalid_i(wvalid), .wready_o(wready), .wdata_i(wdata),
    .rvalid_o(rvalid), .rready_i(rready), .rdata_o(rdata), .full_o(full), .empty_o(empty));

  fifo_pt #(.WIDTH(W), .DEPTH(D), .PASS_THRU(1'b0)) uut_np (
    .clk(clk), .rst(rst), .wvalid_i(np_wvalid), .wready_o(np_wready), .wdata_i(np_wdata),
    .rvalid_o(np_rvalid), .rready_i(np_rready), .rdata_o(np_rdata), .full_o(np_full),
    .empty_o(np_empty));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: record accepted writes, then compare reads in order.
  always @(negedge clk) begin
    if (!rst) begin
      if (wvalid && wready) expq.push_back(wdata);
      if (rvalid && rready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3 read with nothing expected", rdata, 0);
        end else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(rdata == e, "R3 order", rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (3) tick();
    #2;
    chk(empty == 1'b1 && full == 1'b0, "R1 empty/full in reset", {empty, full}, 2'b10);
    chk(rvalid == 1'b0, "R1 rvalid in reset", rvalid, 0);
    chk(wready == 1'b0, "R2 wready in reset", wready, 0);

    tick(); rst = 1'b0; wvalid = 1'b1; wdata = 8'hA5;
    #2;
    chk(!rvalid && !wready, "R2 before first low edge", {rvalid, wready}, 0);
    tick(); #2;
    chk(!rvalid && !wready, "R2 after first low edge", {rvalid, wready}, 0);
    tick(); #2;
    chk(wready == 1'b1, "R2 wready after second edge", wready, 1);
    chk(rvalid && !empty && rdata == 8'hA5, "R6 same-cycle echo", rdata, 8'hA5);

    tick(); wvalid = 1'b0; rready = 1'b1;
    #2;
    chk(rvalid && !empty && rdata == 8'hA5, "R8 stored after unread echo", rdata, 8'hA5);
    tick(); rready = 1'b0;
    #2;
    chk(empty && !rvalid && !full, "R5 drained", {empty, rvalid, full}, 3'b100);

    tick(); wvalid = 1'b1; wdata = 8'h3C; rready = 1'b1;
    #2;
    chk(rvalid && rdata == 8'h3C, "R6 echo with read", rdata, 8'h3C);
    tick(); wvalid = 1'b0; rready = 1'b0;
    #2;
    chk(empty && !rvalid, "R7 bypass not stored", {empty, rvalid}, 2'b10);

    for (int i = 0; i < D; i++) begin
      tick(); wvalid = 1'b1; wdata = 8'h10 + W'(i);
    end
    tick(); wdata = 8'hEE;
    #2;
    chk(full && !wready, "R4 full after DEPTH writes", {full, wready}, 2'b10);
    tick(); wvalid = 1'b0;
    #2;
    chk(full == 1'b1, "R4 full holds", full, 1);

    tick(); rready = 1'b1;
    tick(); rready = 1'b0;
    #2;
    chk(!full && wready, "R9 one slot free", {full, wready}, 2'b01);
    for (int i = 0; i < 5; i++) begin
      tick(); wvalid = 1'b1; rready = 1'b1; wdata = 8'h40 + W'(i);
      #2;
      chk(!full && rvalid && wready, "R9 simultaneous keeps level", {full, rvalid, wready}, 3'b011);
    end
    tick(); rready = 1'b0; wdata = 8'h50;
    #2;
    chk(!full && wready, "R9 level unchanged before last write", full, 0);
    tick(); wvalid = 1'b0;
    #2;
    chk(full == 1'b1, "R9 full after one more write", full, 1);

    rready = 1'b1;
    for (int i = 0; i < 3 * D && rvalid; i++) tick();
    rready = 1'b0;
    #2;
    chk(expq.size() == 0, "R4 rejected write never delivered", expq.size(), 0);
    chk(empty && !rvalid, "R5 empty after drain", {empty, rvalid}, 2'b10);

    tick(); np_wvalid = 1'b1; np_wdata = 8'h77;
    #2;
    chk(!np_rvalid && np_empty, "R10 no echo in plain mode", {np_rvalid, np_empty}, 2'b01);
    tick(); np_wvalid = 1'b0;
    #2;
    chk(np_rvalid && !np_empty && np_rdata == 8'h77, "R10 visible next cycle", np_rdata, 8'h77);
    tick(); np_rready = 1'b1;
    tick(); np_rready = 1'b0;
    #2;
    chk(np_empty && !np_rvalid, "R10 plain drained", {np_empty, np_rvalid}, 2'b10);

    tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule